// File: doc/BRIEF.md
# Delayed Branch Sequencer

This block owns the program counter of a small in-order 32-bit core with 16-bit instructions and delayed branches. Each cycle the decoder presents the instruction that sits at the current PC. If that instruction is a taken branch, the block works out the destination at once and stores it in a pending-target register. It then lets the next sequential instruction, the slot instruction, issue. The PC moves to the stored destination only after that slot instruction. Because the fetch that was already under way is always used, a taken branch discards nothing.

There are three kinds of branch. A register-indirect jump takes its destination from the register-file read value. A PC-relative jump adds a scaled, sign-extended displacement to the PC. Two conditional forms test the single comparison flag T, one taken when T is set and one taken when T is clear. The destination is fixed in the branch's own cycle, so a slot instruction that overwrites the source register does not move the branch. A branch decoded in a slot is illegal: it raises a flag, sends the PC to the exception vector and drops the pending destination. A stall input freezes the whole sequencing state.

Top module: `dbr_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters its reset state: `pc` equals RESET_VEC, `slot_active` is 0, and `next_pc` shows RESET_VEC.
- R2: With no pending destination and no branch in a slot, `next_pc` is `pc + 2`, and `pc` takes that value at the next unstalled edge.
- R3: A taken branch decoded at address A makes the next cycle a slot cycle: `pc = A + 2` and `slot_active = 1`. In the cycle after the slot, `pc` is the branch destination and `slot_active` is 0, so no instruction is skipped.
- R4: `br_kind = 2'b00` (register-indirect, always taken). The destination is the `reg_val` sampled in the branch cycle. Any `reg_val` seen during the slot cycle has no effect on where the PC goes.
- R5: `br_kind = 2'b01` (PC-relative, always taken). The destination is `A + 4 + 2*sext(br_disp)`, where `br_disp` is a DISP_W-bit two's-complement value and the sum wraps modulo 2^32.
- R6: `br_kind = 2'b10` is taken only when `t_flag = 1`, and `br_kind = 2'b11` only when `t_flag = 0`. Both use the R5 destination. A conditional branch that is not taken behaves as a non-branch: no slot follows and the PC advances by 2.
- R7: A branch (`br_valid = 1`, any kind) decoded while `slot_active = 1` drives `illegal_slot = 1` and `next_pc = EXC_VEC`. After the next unstalled edge, `pc = EXC_VEC` and `slot_active = 0`. The pending destination is never applied.
- R8: While `stall = 1`, `pc`, `slot_active` and the pending destination hold their values. When the stall is released, sequencing resumes exactly where it stopped.
- R9: Register-indirect and PC-relative branches are taken whatever the value of `t_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold all sequencing state this cycle |
| br_valid | input | 1 | The instruction at `pc` is a branch |
| br_kind | input | 2 | 00 reg-indirect, 01 PC-relative, 10 if T set, 11 if T clear |
| br_disp | input | DISP_W | Signed displacement, in instructions |
| reg_val | input | 32 | Register-file read value for a reg-indirect destination |
| t_flag | input | 1 | Comparison flag T |
| pc | output | 32 | Address of the instruction currently decoded |
| next_pc | output | 32 | Address that `pc` takes at the next unstalled edge |
| slot_active | output | 1 | The current instruction is a delay-slot instruction |
| illegal_slot | output | 1 | A branch was decoded in a delay slot |

## Verification
The embedded assertions check, on every cycle, the properties that hold in general:
- `pc` follows `next_pc` on each unstalled edge.
- A stall freezes `pc` and the slot state.
- A slot never follows another slot.
- A branch in a slot always lands on the exception vector.
- Reset forces the reset vector.

Only the bench scenarios can show that the stored destination is the correct one. The bench covers every displacement value, register values that are changed during the slot, all four kind-and-flag combinations, and stalls that fall on both the branch cycle and the slot cycle.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    localparam int ADDR_W     = 32;
    localparam int INSN_BYTES = 2;
    localparam int SLOT_SKIP  = 4;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        BK_REG   = 2'b00,
        BK_REL   = 2'b01,
        BK_IF_T  = 2'b10,
        BK_IF_NT = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        SEL_RESET,
        SEL_EXC,
        SEL_PEND,
        SEL_SEQ
    } npc_sel_e;

    typedef struct packed {
        logic  valid;
        addr_t target;
    } pend_t;

    function automatic addr_t seq_next(input addr_t cur);
        return cur + addr_t'(INSN_BYTES);
    endfunction

    function automatic logic is_taken(input br_kind_e k, input logic t);
        case (k)
            BK_REG, BK_REL: return 1'b1;
            BK_IF_T:        return t;
            default:        return ~t;
        endcase
    endfunction
endpackage

// File: rtl/dbr_target.sv
module dbr_target
    import dbr_pkg::*;
#(
    parameter int DISP_W = 12
) (
    input  addr_t             cur_pc,
    input  br_kind_e          kind,
    input  logic [DISP_W-1:0] disp,
    input  addr_t             reg_val,
    input  logic              t_flag,
    output addr_t             target,
    output logic              taken
);
    localparam int EXT_W = ADDR_W - DISP_W;

    addr_t disp_ext;
    addr_t rel_tgt;

    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        rel_tgt  = cur_pc + addr_t'(SLOT_SKIP) + (disp_ext << 1);
        target   = (kind == BK_REG) ? reg_val : rel_tgt;
        taken    = is_taken(kind, t_flag);
    end
endmodule

// File: rtl/dbr_pend.sv
module dbr_pend
    import dbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stall,
    input  logic  capture,
    input  addr_t target_in,
    output pend_t pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (!stall) begin
            pend.valid <= capture;
            if (capture) begin
                pend.target <= target_in;
            end
        end
    end

    // R3: a pending destination lives for exactly one unstalled cycle
    assert_pend_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        pend.valid && !stall |=> !pend.valid);

    // R8: stall freezes the pending state
    assert_pend_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pend));
endmodule

// File: rtl/dbr_npc.sv
module dbr_npc
    import dbr_pkg::*;
#(
    parameter addr_t RESET_VEC = 32'hA000_0000,
    parameter addr_t EXC_VEC   = 32'hA000_0100
) (
    input  logic  rst,
    input  logic  illegal,
    input  pend_t pend,
    input  addr_t cur_pc,
    output addr_t next_pc
);
    npc_sel_e sel;

    always_comb begin
        if (rst)             sel = SEL_RESET;
        else if (illegal)    sel = SEL_EXC;
        else if (pend.valid) sel = SEL_PEND;
        else                 sel = SEL_SEQ;

        case (sel)
            SEL_RESET: next_pc = RESET_VEC;
            SEL_EXC:   next_pc = EXC_VEC;
            SEL_PEND:  next_pc = pend.target;
            default:   next_pc = seq_next(cur_pc);
        endcase
    end
endmodule

// File: rtl/dbr_seq.sv
module dbr_seq
    import dbr_pkg::*;
#(
    parameter int    DISP_W    = 12,
    parameter addr_t RESET_VEC = 32'hA000_0000,
    parameter addr_t EXC_VEC   = 32'hA000_0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              br_valid,
    input  logic [1:0]        br_kind,
    input  logic [DISP_W-1:0] br_disp,
    input  logic [31:0]       reg_val,
    input  logic              t_flag,
    output logic [31:0]       pc,
    output logic [31:0]       next_pc,
    output logic              slot_active,
    output logic              illegal_slot
);
    addr_t pc_q;
    addr_t tgt;
    addr_t npc;
    logic  tk;
    logic  capture;
    pend_t pend;

    dbr_target #(.DISP_W(DISP_W)) u_target (
        .cur_pc  (pc_q),
        .kind    (br_kind_e'(br_kind)),
        .disp    (br_disp),
        .reg_val (reg_val),
        .t_flag  (t_flag),
        .target  (tgt),
        .taken   (tk)
    );

    assign illegal_slot = pend.valid & br_valid & ~rst;
    assign capture      = br_valid & tk & ~pend.valid;

    dbr_pend u_pend (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .capture   (capture),
        .target_in (tgt),
        .pend      (pend)
    );

    dbr_npc #(.RESET_VEC(RESET_VEC), .EXC_VEC(EXC_VEC)) u_npc (
        .rst     (rst),
        .illegal (illegal_slot),
        .pend    (pend),
        .cur_pc  (pc_q),
        .next_pc (npc)
    );

    always_ff @(posedge clk) begin
        if (rst)         pc_q <= RESET_VEC;
        else if (!stall) pc_q <= npc;
    end

    assign pc          = pc_q;
    assign next_pc     = npc;
    assign slot_active = pend.valid;

    // R1: reset lands on the reset vector with no slot
    assert_reset_vec_R1: assert property (@(posedge clk)
        rst |=> pc == RESET_VEC && !slot_active);

    // R2: the PC follows the announced next address
    assert_pc_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !stall |=> pc == $past(next_pc));

    // R7: a branch in a slot goes to the exception vector and ends the slot
    assert_slot_branch_exc_R7: assert property (@(posedge clk) disable iff (rst)
        illegal_slot && !stall |=> pc == EXC_VEC && !slot_active);

    // R8: stall freezes the PC and the slot indication
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc) && $stable(slot_active));

    // R3: a taken branch outside a slot opens a slot cycle
    assert_slot_opens_R3: assert property (@(posedge clk) disable iff (rst)
        capture && !stall |=> slot_active && pc == $past(pc) + 32'd2);
endmodule

// File: tb/dbr_seq_bench.sv
module dbr_seq_bench;
    localparam logic [31:0] RESET_VEC = 32'hA000_0000;
    localparam logic [31:0] EXC_VEC   = 32'hA000_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic        br_valid = 1'b0;
    logic [1:0]  br_kind = 2'b00;
    logic [11:0] br_disp = '0;
    logic [31:0] reg_val = '0;
    logic        t_flag = 1'b0;
    logic [31:0] pc, next_pc;
    logic        slot_active, illegal_slot;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_pc;
    logic        m_pv;
    logic [31:0] m_pt;

    always #4 clk = ~clk;

    dbr_seq u_dbr_seq (
        .clk(clk), .rst(rst), .stall(stall), .br_valid(br_valid),
        .br_kind(br_kind), .br_disp(br_disp), .reg_val(reg_val),
        .t_flag(t_flag), .pc(pc), .next_pc(next_pc),
        .slot_active(slot_active), .illegal_slot(illegal_slot)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One decoded cycle: drive, compare with the bench model, clock, update model
    task automatic cyc(input logic bv, input logic [1:0] k, input logic [11:0] d,
                       input logic [31:0] rv, input logic t, input logic st,
                       input string tag);
        logic        tk;
        logic        ill;
        logic [31:0] tgt;
        logic [31:0] np;
        br_valid = bv; br_kind = k; br_disp = d; reg_val = rv;
        t_flag = t; stall = st;
        #1;
        tk  = bv && (k == 2'b00 || k == 2'b01 || (k == 2'b10 && t) || (k == 2'b11 && !t));
        tgt = (k == 2'b00) ? rv : m_pc + 32'd4 + ({{20{d[11]}}, d} << 1);
        ill = m_pv && bv;
        if (ill)       np = EXC_VEC;
        else if (m_pv) np = m_pt;
        else           np = m_pc + 32'd2;
        chk(pc == m_pc, {tag, " pc"}, pc, m_pc);
        chk(slot_active == m_pv, {tag, " slot"}, 32'(slot_active), 32'(m_pv));
        chk(next_pc == np, {tag, " next_pc"}, next_pc, np);
        chk(illegal_slot == ill, {tag, " illegal R7"}, 32'(illegal_slot), 32'(ill));
        @(posedge clk);
        if (!st) begin
            if (tk && !m_pv) begin m_pv = 1'b1; m_pt = tgt; end
            else m_pv = 1'b0;
            m_pc = np;
        end
        @(negedge clk);
    endtask

    initial begin
        m_pc = RESET_VEC; m_pv = 1'b0; m_pt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pc == RESET_VEC, "R1 reset pc", pc, RESET_VEC);
        chk(next_pc == RESET_VEC, "R1 reset next_pc", next_pc, RESET_VEC);
        chk(slot_active == 1'b0, "R1 reset slot", 32'(slot_active), 32'd0);
        rst = 1'b0;

        // R2: plain sequential flow
        for (int i = 0; i < 8; i++) cyc(1'b0, 2'b00, 12'h0, 32'h0, i[0], 1'b0, "R2 seq");

        // R5 / R3 / R9: every PC-relative displacement, then the slot
        for (int d = 0; d < 4096; d++) begin
            cyc(1'b1, 2'b01, d[11:0], 32'hDEAD_BEEE, d[0], 1'b0, "R5 R9 rel branch");
            cyc(1'b0, 2'b00, 12'h0, 32'h0, 1'b0, 1'b0, "R3 rel slot");
        end

        // R4 / R9: register-indirect, slot rewrites the register
        for (int i = 0; i < 64; i++) begin
            logic [31:0] v;
            v = (32'h1357_9BDF * (i + 1)) & 32'hFFFF_FFFE;
            cyc(1'b1, 2'b00, 12'h7FF, v, i[1], 1'b0, "R4 R9 reg branch");
            cyc(1'b0, 2'b00, 12'h0, ~v, 1'b0, 1'b0, "R4 slot rewrites reg");
            chk(pc == v, "R4 landed on pre-slot reg value", pc, v);
            cyc(1'b0, 2'b00, 12'h0, 32'h0, 1'b0, 1'b0, "R2 after reg branch");
        end

        // R6: every kind-and-flag combination of conditionals
        for (int i = 0; i < 64; i++) begin
            logic [1:0] k;
            k = (i[0]) ? 2'b11 : 2'b10;
            cyc(1'b1, k, 12'(i * 37), 32'h0, i[1], 1'b0, "R6 cond branch");
            cyc(1'b0, 2'b00, 12'h0, 32'h0, 1'b0, 1'b0, "R6 after cond");
        end

        // R7: a branch of each kind inside a slot
        for (int k = 0; k < 4; k++) begin
            cyc(1'b1, 2'b01, 12'h010, 32'h0, 1'b0, 1'b0, "R7 first branch");
            cyc(1'b1, k[1:0], 12'h020, 32'h0000_4000, 1'b1, 1'b0, "R7 branch in slot");
            chk(pc == EXC_VEC, "R7 exception vector", pc, EXC_VEC);
            chk(slot_active == 1'b0, "R7 slot dropped", 32'(slot_active), 32'd0);
            cyc(1'b0, 2'b00, 12'h0, 32'h0, 1'b0, 1'b0, "R7 after exception");
        end

        // R8: stalls on the branch cycle and in the slot
        for (int n = 1; n < 5; n++) begin
            for (int s = 0; s < n; s++)
                cyc(1'b1, 2'b00, 12'h0, 32'h0000_8000 + 32'(n * 16), 1'b0, 1'b1, "R8 stall on branch");
            cyc(1'b1, 2'b00, 12'h0, 32'h0000_8000 + 32'(n * 16), 1'b0, 1'b0, "R8 branch issues");
            for (int s = 0; s < n; s++)
                cyc(1'b0, 2'b00, 12'h0, 32'h1111_0000, 1'b0, 1'b1, "R8 stall in slot");
            cyc(1'b0, 2'b00, 12'h0, 32'h0, 1'b0, 1'b0, "R8 slot resumes");
            chk(pc == 32'h0000_8000 + 32'(n * 16), "R8 redirect after stall",
                pc, 32'h0000_8000 + 32'(n * 16));
        end

        // R1: reset in the middle of a slot
        cyc(1'b1, 2'b01, 12'h040, 32'h0, 1'b0, 1'b0, "R1 branch before reset");
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(pc == RESET_VEC, "R1 mid-slot reset pc", pc, RESET_VEC);
        chk(slot_active == 1'b0, "R1 mid-slot reset slot", 32'(slot_active), 32'd0);
        rst = 1'b0;
        m_pc = RESET_VEC; m_pv = 1'b0;
        cyc(1'b0, 2'b00, 12'h0, 32'h0, 1'b0, 1'b0, "R2 after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule